// File: doc/BRIEF.md
# DRAM Row-Strobe and Refresh Sequencer

This block drives the row strobes (one active-low line per bank, four banks) and the shared active-low column strobe of an asynchronous DRAM array. It runs on the CPU clock. Every memory-cycle timing is counted in memory clocks, and one memory clock is two CPU clocks. A configuration is presented on dedicated inputs: per-bank enables, a 4-bit precharge count, a 4-bit refresh row-strobe width, a 2-bit read-latch delay, a column-timing divide select and a 15-bit refresh interval. The configuration is sampled at the start of every cycle.

A client holds `req` with a bank index and a write flag until `ack` pulses. An access to an enabled bank opens that bank's row strobe and then the column strobe. An access to a disabled bank opens no row. It is replaced by one column-before-row refresh of every bank, and the client is acknowledged when that refresh ends. An interval timer raises a pending refresh while any bank is enabled. The pending refresh is served ahead of a waiting access. Every cycle is followed by a precharge with both strobes high. After a read, a one-cycle strobe marks the point where read data is latched.

Top module: `dram_ras_seq`

## Requirements
- R1: After reset, `ras_n` is 4'b1111, `cas_n` is 1, and `busy`, `ack` and `rd_latch` are 0.
- R2: An access (`req_wr`=0 read, 1 write) to an enabled bank pulls low only `ras_n[req_bank]`. It stays low for 2 CPU cycles with `cas_n` high, then `cas_n` falls. Both strobes rise on the same edge, and `ack` is high for exactly that first high cycle.
- R3: An access to a bank whose enable bit is 0 opens no single-bank row. It runs exactly one all-bank refresh and is acknowledged in the first cycle after that refresh ends.
- R4: Between two cycles, both strobes are high for at least 2*max(TRP+1,2) CPU cycles. When the next cycle is already waiting, the gap is exactly that long, whether the next cycle is an access or a refresh.
- R5: In a refresh, `cas_n` falls 2 CPU cycles before all four `ras_n` fall. `ras_n` stays 4'b0000 for 2*(TRASR+1) CPU cycles, and `cas_n` rises on the same edge as `ras_n`.
- R6: After a read, `rd_latch` pulses for one CPU cycle, TDL CPU cycles after the first cycle in which `cas_n` is high again (TDL=0 means that same cycle). Writes and refreshes produce no pulse.
- R7: With `cfg_cas_div`=0 the column strobe of an access stays low for CAS_STEPS CPU cycles. With `cfg_cas_div`=1 it stays low for 2*CAS_STEPS CPU cycles.
- R8: While any enable bit is set and the block is otherwise idle, refreshes begin every 2*(IVAL+1) CPU cycles, where IVAL is `cfg_rfsh_ival`.
- R9: While all enable bits are 0, no periodic refresh is issued.
- R10: A `ras_n` line of a disabled bank is never low, except while all four lines are low in a refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bank_en | input | 4 | Per-bank enable |
| cfg_trp | input | 4 | Precharge count TRP |
| cfg_trasr | input | 4 | Refresh row-strobe width count TRASR |
| cfg_tdl | input | 2 | Read latch delay in CPU clocks |
| cfg_cas_div | input | 1 | Column timing step: 0 CPU clock, 1 memory clock |
| cfg_rfsh_ival | input | 15 | Refresh interval in memory clocks, minus one |
| req | input | 1 | Access request, held until ack |
| req_bank | input | 2 | Target bank |
| req_wr | input | 1 | 1 write, 0 read |
| busy | output | 1 | A cycle or precharge is in progress |
| ack | output | 1 | One-cycle completion pulse |
| ras_n | output | 4 | Active-low row strobes, one per bank |
| cas_n | output | 1 | Active-low column strobe |
| rd_latch | output | 1 | Read data latch strobe |

## Verification
The bench sweeps all 16 precharge and 16 refresh-width values and all four latch delays. It measures each gap and strobe width in CPU cycles at the pins. A design that took the plain TRP+1 would show a 2-cycle gap at TRP=0. An off-by-one in the refresh width would stretch or shorten the all-low window. A wrong latch counter would move the read strobe off its TDL slot or fire it on writes. Back-to-back chains end in a refresh, which exposes a design that opens a disabled bank's row or never acknowledges the substitute cycle. A halted-timer interval exposes one that keeps refreshing with every bank disabled.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
    localparam int NB     = 4;
    localparam int BW     = $clog2(NB);
    localparam int IVAL_W = 15;
    localparam int CNT_W  = 7;

    typedef struct packed {
        logic [NB-1:0] bank_en;
        logic [3:0]    trp;
        logic [3:0]    trasr;
        logic [1:0]    tdl;
        logic          cas_div;
    } cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ACT, ST_CAS, ST_RCAS, ST_RRAS, ST_PRE
    } st_t;

    // precharge length in CPU cycles: two per memory clock, at least 2 memory clocks
    function automatic logic [CNT_W-1:0] pre_len(input logic [3:0] trp);
        logic [CNT_W-1:0] n;
        n = CNT_W'(trp) + CNT_W'(1);
        if (n < CNT_W'(2)) n = CNT_W'(2);
        return n << 1;
    endfunction

    function automatic logic [CNT_W-1:0] cbr_len(input logic [3:0] trasr);
        return (CNT_W'(trasr) + CNT_W'(1)) << 1;
    endfunction

    function automatic logic [CNT_W-1:0] cas_len(input logic div, input int steps);
        return div ? CNT_W'(2 * steps) : CNT_W'(steps);
    endfunction
endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer
    import dram_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              en_any,
    input  logic [IVAL_W-1:0] ival,
    input  logic              clr,
    output logic              pend
);
    logic [IVAL_W-1:0] cnt;
    logic              expire;

    assign expire = en_any && tick && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= ival;
            pend <= 1'b0;
        end else begin
            if (!en_any)
                cnt <= ival;
            else if (tick)
                cnt <= (cnt == '0) ? ival : cnt - IVAL_W'(1);
            if (expire)
                pend <= 1'b1;
            else if (clr)
                pend <= 1'b0;
        end
    end

    // R9
    no_rfsh_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (!en_any && !pend) |=> !pend);
endmodule

// File: rtl/rd_latch_gen.sv
module rd_latch_gen (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [1:0] tdl,
    output logic       strobe
);
    logic       act;
    logic [1:0] cnt;

    assign strobe = act && (cnt == 2'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            act <= 1'b0;
            cnt <= 2'd0;
        end else if (start) begin
            act <= 1'b1;
            cnt <= tdl;
        end else if (act) begin
            if (cnt == 2'd0) act <= 1'b0;
            else             cnt <= cnt - 2'd1;
        end
    end

    // R6
    latch_single_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);
endmodule

// File: rtl/ras_cas_fsm.sv
module ras_cas_fsm
    import dram_seq_pkg::*;
#(
    parameter int CAS_STEPS = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  cfg_t          cfg,
    input  logic          pend,
    input  logic          req,
    input  logic [BW-1:0] req_bank,
    input  logic          req_wr,
    output logic          busy,
    output logic          ack,
    output logic [NB-1:0] ras_n,
    output logic          cas_n,
    output logic          pend_clr,
    output logic          lat_start,
    output logic [1:0]    lat_tdl
);
    st_t              st;
    logic [CNT_W-1:0] cnt;
    logic [BW-1:0]    bank_q;
    logic             wr_q;
    logic             sub_q;
    cfg_t             cfg_q;
    logic             go;

    assign go        = (st == ST_IDLE && tick) || (st == ST_PRE && cnt == '0);
    assign pend_clr  = go && pend;
    assign lat_start = (st == ST_CAS) && (cnt == '0) && !wr_q;
    assign lat_tdl   = cfg_q.tdl;
    assign busy      = (st != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            bank_q <= '0;
            wr_q   <= 1'b0;
            sub_q  <= 1'b0;
            cfg_q  <= '0;
            ack    <= 1'b0;
        end else begin
            ack <= 1'b0;
            case (st)
                ST_IDLE, ST_PRE: begin
                    if (go) begin
                        if (pend) begin
                            cfg_q <= cfg;
                            sub_q <= 1'b0;
                            st    <= ST_RCAS;
                            cnt   <= CNT_W'(1);
                        end else if (req) begin
                            cfg_q  <= cfg;
                            bank_q <= req_bank;
                            wr_q   <= req_wr;
                            cnt    <= CNT_W'(1);
                            if (cfg.bank_en[req_bank]) begin
                                st    <= ST_ACT;
                                sub_q <= 1'b0;
                            end else begin
                                st    <= ST_RCAS;
                                sub_q <= 1'b1;
                            end
                        end else begin
                            st <= ST_IDLE;
                        end
                    end else if (st == ST_PRE) begin
                        cnt <= cnt - CNT_W'(1);
                    end
                end
                ST_ACT: begin
                    if (cnt == '0) begin
                        st  <= ST_CAS;
                        cnt <= cas_len(cfg_q.cas_div, CAS_STEPS) - CNT_W'(1);
                    end else cnt <= cnt - CNT_W'(1);
                end
                ST_CAS: begin
                    if (cnt == '0) begin
                        st  <= ST_PRE;
                        cnt <= pre_len(cfg_q.trp) - CNT_W'(1);
                        ack <= 1'b1;
                    end else cnt <= cnt - CNT_W'(1);
                end
                ST_RCAS: begin
                    if (cnt == '0) begin
                        st  <= ST_RRAS;
                        cnt <= cbr_len(cfg_q.trasr) - CNT_W'(1);
                    end else cnt <= cnt - CNT_W'(1);
                end
                ST_RRAS: begin
                    if (cnt == '0) begin
                        st  <= ST_PRE;
                        cnt <= pre_len(cfg_q.trp) - CNT_W'(1);
                        ack <= sub_q;
                    end else cnt <= cnt - CNT_W'(1);
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ras_n = '1;
        if (st == ST_RRAS)
            ras_n = '0;
        else if (st == ST_ACT || st == ST_CAS)
            ras_n[bank_q] = 1'b0;
    end

    assign cas_n = !(st == ST_CAS || st == ST_RCAS || st == ST_RRAS);

    // R10
    dis_bank_ras_chk: assert property (@(posedge clk) disable iff (rst)
        ((~ras_n & ~cfg_q.bank_en) != '0) |-> (ras_n == '0));
    // R5
    cbr_cas_lead_chk: assert property (@(posedge clk) disable iff (rst)
        (ras_n == '0 && $past(ras_n) != '0) |-> $past(!cas_n));
    // R5
    cbr_end_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(ras_n) == '0 && ras_n != '0) |-> cas_n);
    // R2
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);
    // R2
    acc_ras_lead_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(cas_n) && ras_n != '1) |-> ($past(ras_n) == ras_n));
endmodule

// File: rtl/dram_ras_seq.sv
module dram_ras_seq
    import dram_seq_pkg::*;
#(
    parameter int CAS_STEPS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NB-1:0]     cfg_bank_en,
    input  logic [3:0]        cfg_trp,
    input  logic [3:0]        cfg_trasr,
    input  logic [1:0]        cfg_tdl,
    input  logic              cfg_cas_div,
    input  logic [IVAL_W-1:0] cfg_rfsh_ival,
    input  logic              req,
    input  logic [BW-1:0]     req_bank,
    input  logic              req_wr,
    output logic              busy,
    output logic              ack,
    output logic [NB-1:0]     ras_n,
    output logic              cas_n,
    output logic              rd_latch
);
    cfg_t       cfg;
    logic       phase;
    logic       pend, pend_clr, lat_start;
    logic [1:0] lat_tdl;

    assign cfg = '{bank_en: cfg_bank_en, trp: cfg_trp, trasr: cfg_trasr,
                   tdl: cfg_tdl, cas_div: cfg_cas_div};

    // memory clock enable: every second CPU clock
    always_ff @(posedge clk) begin
        if (rst) phase <= 1'b0;
        else     phase <= ~phase;
    end

    rfsh_timer u_tmr (
        .clk(clk), .rst(rst), .tick(phase), .en_any(|cfg_bank_en),
        .ival(cfg_rfsh_ival), .clr(pend_clr), .pend(pend)
    );

    ras_cas_fsm #(.CAS_STEPS(CAS_STEPS)) u_fsm (
        .clk(clk), .rst(rst), .tick(phase), .cfg(cfg), .pend(pend),
        .req(req), .req_bank(req_bank), .req_wr(req_wr),
        .busy(busy), .ack(ack), .ras_n(ras_n), .cas_n(cas_n),
        .pend_clr(pend_clr), .lat_start(lat_start), .lat_tdl(lat_tdl)
    );

    rd_latch_gen u_lat (
        .clk(clk), .rst(rst), .start(lat_start), .tdl(lat_tdl), .strobe(rd_latch)
    );
endmodule

// File: tb/tb_dram_ras_seq.sv
`timescale 1ns/1ps
module tb_dram_ras_seq;
    localparam int CS = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  en;
    logic [3:0]  trp, trasr;
    logic [1:0]  tdl;
    logic        div;
    logic [14:0] ival;
    logic        req, wr;
    logic [1:0]  bank;
    logic        busy, ack, cas_n, rd_latch;
    logic [3:0]  ras_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    dram_ras_seq #(.CAS_STEPS(CS)) dut (
        .clk(clk), .rst(rst), .cfg_bank_en(en), .cfg_trp(trp), .cfg_trasr(trasr),
        .cfg_tdl(tdl), .cfg_cas_div(div), .cfg_rfsh_ival(ival),
        .req(req), .req_bank(bank), .req_wr(wr),
        .busy(busy), .ack(ack), .ras_n(ras_n), .cas_n(cas_n), .rd_latch(rd_latch)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_pre(input int p);
        return 2 * ((p + 1) > 2 ? (p + 1) : 2);
    endfunction
    function automatic int exp_cbr(input int t);
        return 2 * (t + 1);
    endfunction
    function automatic int exp_cas(input bit d);
        return d ? 2 * CS : CS;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // one request; samples at negedges from the current one onward
    task automatic run_cyc(input logic [1:0] b, input bit w, input bit hold,
                           input logic [1:0] nb, input bit nw);
        bit hit = en[b];
        int cas_lo = 0, ras_all = 0, cas_lead = 0, ras_lead = 0, t = 0;
        int k = 0, nstr = 0, str_at = -1;
        bit bad = 0;
        req = 1'b1; bank = b; wr = w;
        while (!ack && t < 600) begin
            if (!cas_n) cas_lo++;
            if (ras_n == 4'h0) ras_all++;
            if (!cas_n && ras_n == 4'hf) cas_lead++;
            if (cas_n && ras_n == ~(4'b1 << b)) ras_lead++;
            if (ras_n != 4'hf && ras_n != 4'h0 && (!hit || ras_n != ~(4'b1 << b))) bad = 1;
            t++;
            @(negedge clk);
        end
        chk(ack, "R2 ack seen", int'(ack), 1);
        if (hit) begin
            chk(cas_lo == exp_cas(div), "R7 cas low width", cas_lo, exp_cas(div));
            chk(ras_lead == 2, "R2 row lead", ras_lead, 2);
            chk(ras_all == 0, "R2 no refresh", ras_all, 0);
            chk(!bad, "R10 only target row", int'(bad), 0);
        end else begin
            chk(ras_all == exp_cbr(trasr), "R5 refresh row width", ras_all, exp_cbr(trasr));
            chk(cas_lead == 2, "R5 cas lead", cas_lead, 2);
            chk(cas_lo == exp_cbr(trasr) + 2, "R5 cas span", cas_lo, exp_cbr(trasr) + 2);
            chk(!bad, "R3 no single row on disabled bank", int'(bad), 0);
        end
        if (hold) begin bank = nb; wr = nw; end
        else req = 1'b0;
        while (ras_n == 4'hf && cas_n && k < 40) begin
            if (rd_latch) begin nstr++; str_at = k; end
            k++;
            @(negedge clk);
        end
        if (hit && !w)
            chk(nstr == 1 && str_at == int'(tdl), "R6 latch offset", str_at, int'(tdl));
        else
            chk(nstr == 0, "R6 no latch", nstr, 0);
        if (hold)
            chk(k == exp_pre(trp), "R4 back-to-back gap", k, exp_pre(trp));
        else
            chk(k >= exp_pre(trp), "R4 minimum gap", k, exp_pre(trp));
    endtask

    initial begin
        int f1, f2, f3, nf;
        bit pc;
        void'($urandom(32'h1d5a7c3));
        rst = 1; req = 0; bank = 0; wr = 0;
        en = 0; trp = 0; trasr = 0; tdl = 0; div = 0; ival = 15'd20;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(ras_n == 4'hf && cas_n && !busy && !ack && !rd_latch, "R1 reset state",
            {27'd0, ras_n, cas_n}, 31);

        // periodic refresh spacing
        en = 4'hf;
        f1 = -1; f2 = -1; f3 = -1; pc = 1;
        for (int i = 0; i < 200 && f3 < 0; i++) begin
            @(negedge clk);
            if (pc && !cas_n) begin
                if (f1 < 0) f1 = i; else if (f2 < 0) f2 = i; else f3 = i;
            end
            pc = cas_n;
        end
        chk(f2 - f1 == 42, "R8 refresh period", f2 - f1, 42);
        chk(f3 - f2 == 42, "R8 refresh period", f3 - f2, 42);

        // halt with all banks disabled
        while (busy) @(negedge clk);
        en = 4'h0;
        repeat (50) @(negedge clk);
        ival = 15'h7fff;
        nf = 0; pc = cas_n;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (pc && !cas_n) nf++;
            pc = cas_n;
        end
        chk(nf == 0, "R9 halted timer", nf, 0);
        repeat (4) @(negedge clk);

        // refresh width sweep via disabled-bank access
        en = 4'b0001;
        for (int t = 0; t < 16; t++) begin
            trasr = 4'(t); trp = 4'($urandom_range(0, 15));
            run_cyc(2'd3, 1'b0, 1'b0, 2'd0, 1'b0);
        end
        // latch delay sweep, reads and writes
        en = 4'hf;
        for (int d = 0; d < 4; d++) begin
            tdl = 2'(d);
            run_cyc(2'($urandom_range(0, 3)), 1'b0, 1'b0, 2'd0, 1'b0);
            run_cyc(2'($urandom_range(0, 3)), 1'b1, 1'b0, 2'd0, 1'b0);
        end
        // column step rate
        for (int d = 0; d < 2; d++) begin
            div = d[0];
            run_cyc(2'd1, 1'b0, 1'b0, 2'd0, 1'b0);
        end
        div = 0;
        // precharge sweep with back-to-back traffic, next access or substitute refresh
        en = 4'b0011;
        for (int p = 0; p < 16; p++) begin
            trp = 4'(p);
            run_cyc(2'd0, 1'b0, 1'b1, p[0] ? 2'd2 : 2'd1, 1'b1);
            run_cyc(p[0] ? 2'd2 : 2'd1, 1'b1, 1'b0, 2'd0, 1'b0);
        end
        // constrained random mix
        for (int i = 0; i < 40; i++) begin
            logic [1:0] b0, b1;
            bit h, w0, w1;
            en = 4'($urandom); trp = 4'($urandom); trasr = 4'($urandom);
            tdl = 2'($urandom); div = 1'($urandom);
            b0 = 2'($urandom); b1 = 2'($urandom);
            w0 = 1'($urandom); w1 = 1'($urandom); h = 1'($urandom);
            run_cyc(b0, w0, h, b1, w1);
            if (h) run_cyc(b1, w1, 1'b0, 2'd0, 1'b0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule